// File: doc/BRIEF.md
# Dual Countdown Timers with Prescale

This block holds two independent 8-bit down-counters that share a free-running prescaler driven by the system clock. The first timer steps on either a divide-by-4 or a divide-by-1024 tick. When it passes zero it rolls over to 0xFF. The second timer steps on the divide-by-4 tick or on rising edges of an external event pin. When it passes zero it reloads its programmed start value.

Each timer raises its own sticky interrupt flag when it passes zero. Software clears a flag with a one-cycle strobe. A processor programs the block through three kinds of write strobe: a preset write for each timer, a control write, and a flag-clear strobe for each timer. The live counts and the flags appear directly on output ports.

Top module: `dual_tmr`

## Requirements
- R1: After synchronous reset, both counts read 0x00, both flags read 0, and both timers are stopped with the divide-by-4 tick and internal counting selected.
- R2: With control bit 0 set (timer A run) and control bit 1 clear, timer A decrements once every 4 clock cycles.
- R3: With control bits 0 and 1 both set, timer A decrements once every 1024 clock cycles.
- R4: Timer A steps from 0x00 to 0xFF on the tick after it reaches zero.
- R5: Timer B steps from 0x00 to its last preset value on the tick after it reaches zero.
- R6: With control bit 2 set (timer B run) and control bit 3 clear, timer B decrements once every 4 clock cycles.
- R7: With control bits 2 and 3 both set, timer B decrements exactly once for each rising edge of `evt_pin`. The new count shows after the third rising clock edge that follows the pin's rise, and the internal tick has no effect in this mode.
- R8: A preset write (`preset_wr[0]` for timer A, `preset_wr[1]` for timer B) makes the count equal `preset_data` on the next cycle and stores it as that timer's reload value. The write wins over a tick in the same cycle.
- R9: While a timer's run bit is clear, its count holds, even if ticks or event-pin edges arrive.
- R10: A timer's flag (`irq_flag[0]` for A, `irq_flag[1]` for B) sets on the cycle that the timer passes zero and stays set until it is cleared.
- R11: A clear strobe (`flag_clr[i]`) drops the flag on the next cycle, and it wins over a zero-crossing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| preset_wr | input | 2 | Per-timer preset write strobe (bit 0 timer A, bit 1 timer B) |
| preset_data | input | 8 | Value for a preset write |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 4 | Control value: bit0 A run, bit1 A slow tick, bit2 B run, bit3 B event mode |
| flag_clr | input | 2 | Per-timer flag clear strobe |
| evt_pin | input | 1 | Asynchronous external event input for timer B |
| t0_count | output | 8 | Live count of timer A |
| t1_count | output | 8 | Live count of timer B |
| irq_flag | output | 2 | Sticky zero-crossing flags (bit 0 A, bit 1 B) |

## Verification
The hardest case to reach is a flag clear that falls in the same cycle as a zero-crossing. With an internal tick, that cycle depends on the prescaler phase, which the ports do not expose. The bench therefore runs timer B in event mode. It raises the pin on a falling clock edge, counts the two synchronizer stages and the edge register, and holds the clear strobe across exactly the rising clock edge where the reload happens. The tick periods are measured from the ports between two observed count changes, so the result does not depend on the prescaler phase. A sweep of small presets checks each event-mode decrement, the reload and the flag arithmetically.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;

    // Control register layout; bit order is the software encoding
    typedef struct packed {
        logic t1_ext;   // bit 3: timer B counts event-pin edges
        logic t1_run;   // bit 2: timer B enabled
        logic t0_slow;  // bit 1: timer A uses the slow tap
        logic t0_run;   // bit 0: timer A enabled
    } tmr_ctl_t;

    localparam tmr_ctl_t CTL_RESET = '0;

    // Per-timer step source
    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_SLOW  = 2'd1,
        SRC_EVENT = 2'd2
    } tick_src_e;

    function automatic tick_src_e t0_source(tmr_ctl_t c);
        return c.t0_slow ? SRC_SLOW : SRC_FAST;
    endfunction

    function automatic tick_src_e t1_source(tmr_ctl_t c);
        return c.t1_ext ? SRC_EVENT : SRC_FAST;
    endfunction

    function automatic logic pick_tick(tick_src_e s, logic fast, logic slow, logic evt);
        case (s)
            SRC_SLOW:  return slow;
            SRC_EVENT: return evt;
            default:   return fast;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int SLOW_W = $clog2(SLOW_DIV);
    localparam int FAST_W = $clog2(FAST_DIV);

    logic [SLOW_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + SLOW_W'(1);
    end

    assign tick_fast = &div_q[FAST_W-1:0];
    assign tick_slow = &div_q;

    // R3
    slow_in_fast_chk: assert property (@(posedge clk) disable iff (rst)
        tick_slow |-> tick_fast);

    // R2
    fast_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_fast |=> !tick_fast);

endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

    // R7
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tmr_down_counter.sv
`timescale 1ns/1ps
module tmr_down_counter #(
    parameter int W           = 8,
    parameter bit AUTO_RELOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         flag
);
    logic [W-1:0] count_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] wrap_val;
    logic         step;
    logic         under;

    generate
        if (AUTO_RELOAD) begin : g_reload
            assign wrap_val = reload_q;
        end else begin : g_wrap
            assign wrap_val = '1;
        end
    endgenerate

    assign step  = run && tick && !load;
    assign under = step && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else if (load) begin
            count_q  <= load_val;
            reload_q <= load_val;
        end else if (step) begin
            count_q  <= under ? wrap_val : count_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (clr)   flag <= 1'b0;
        else if (under) flag <= 1'b1;
    end

    assign count = count_q;

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> count == $past(count));

    // R2
    dec_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && count != '0) |=> count == $past(count) - W'(1));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!AUTO_RELOAD && run && tick && !load && count == '0) |=> count == '1);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load && count == '0 && !clr) |=> flag);

    // R11
    clr_win_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/dual_tmr.sv
`timescale 1ns/1ps
module dual_tmr
    import dtmr_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 1024,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       preset_wr,
    input  logic [CNT_W-1:0] preset_data,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_data,
    input  logic [1:0]       flag_clr,
    input  logic             evt_pin,
    output logic [CNT_W-1:0] t0_count,
    output logic [CNT_W-1:0] t1_count,
    output logic [1:0]       irq_flag
);
    tmr_ctl_t ctl_q;
    logic     tick_fast, tick_slow, evt_rise;
    logic     tick_a, tick_b;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (ctl_wr) ctl_q <= tmr_ctl_t'(ctl_data);
    end

    tmr_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow)
    );

    tmr_edge_sync #(.STAGES(SYNC_LEN)) u_evt (
        .clk(clk), .rst(rst), .pin(evt_pin), .rise(evt_rise)
    );

    assign tick_a = pick_tick(t0_source(ctl_q), tick_fast, tick_slow, evt_rise);
    assign tick_b = pick_tick(t1_source(ctl_q), tick_fast, tick_slow, evt_rise);

    tmr_down_counter #(.W(CNT_W), .AUTO_RELOAD(1'b0)) u_tmr_a (
        .clk(clk), .rst(rst),
        .load(preset_wr[0]), .load_val(preset_data),
        .run(ctl_q.t0_run), .tick(tick_a), .clr(flag_clr[0]),
        .count(t0_count), .flag(irq_flag[0])
    );

    tmr_down_counter #(.W(CNT_W), .AUTO_RELOAD(1'b1)) u_tmr_b (
        .clk(clk), .rst(rst),
        .load(preset_wr[1]), .load_val(preset_data),
        .run(ctl_q.t1_run), .tick(tick_b), .clr(flag_clr[1]),
        .count(t1_count), .flag(irq_flag[1])
    );

    // R7
    evt_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.t1_ext && ctl_q.t1_run && !preset_wr[1] && !evt_rise)
            |=> t1_count == $past(t1_count));

endmodule

// File: tb/dual_tmr_tb.sv
`timescale 1ns/1ps
module dual_tmr_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] preset_wr = '0;
    logic [7:0] preset_data = '0;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_data = '0;
    logic [1:0] flag_clr = '0;
    logic       evt_pin = 1'b0;
    logic [7:0] t0_count, t1_count;
    logic [1:0] irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_tmr u_dut (
        .clk(clk), .rst(rst), .preset_wr(preset_wr), .preset_data(preset_data),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data), .flag_clr(flag_clr),
        .evt_pin(evt_pin), .t0_count(t0_count), .t1_count(t1_count),
        .irq_flag(irq_flag)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_of(int sel);
        return (sel == 0) ? int'(t0_count) : int'(t1_count);
    endfunction

    task automatic wr_preset(int sel, logic [7:0] v);
        @(negedge clk);
        preset_wr[sel] = 1'b1;
        preset_data    = v;
        @(negedge clk);
        preset_wr = '0;
    endtask

    task automatic wr_ctl(logic [3:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_data = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic clr_flag(int sel);
        @(negedge clk);
        flag_clr[sel] = 1'b1;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic measure(int sel, output int cyc);
        int prev;
        prev = cnt_of(sel);
        cyc = 0;
        while (cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (cnt_of(sel) != prev) break;
        end
    endtask

    task automatic wait_value(int sel, int v);
        for (int i = 0; i < 5000; i++) begin
            if (cnt_of(sel) == v) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse();
        @(negedge clk); evt_pin = 1'b1;
        repeat (4) @(negedge clk);
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(t0_count == 0, "R1 t0_count", t0_count, 0);
        check(t1_count == 0, "R1 t1_count", t1_count, 0);
        check(irq_flag == 0, "R1 irq_flag", irq_flag, 0);
        repeat (12) @(negedge clk);
        check(t0_count == 0 && irq_flag == 0, "R1 stopped after reset", t0_count, 0);

        // R8 preset load visible next cycle; R9 stopped timer holds
        wr_preset(0, 8'h05);
        check(t0_count == 8'h05, "R8 preset load A", t0_count, 5);
        repeat (20) @(negedge clk);
        check(t0_count == 8'h05, "R9 stopped hold A", t0_count, 5);

        // R2 fast tap period
        wr_ctl(4'b0001);
        measure(0, c);
        measure(0, c);
        check(c == 4, "R2 fast period A", c, 4);
        measure(0, c);
        check(c == 4, "R2 fast period A again", c, 4);

        // R4 wrap and R10 flag
        wait_value(0, 0);
        check(irq_flag[0] == 1'b0, "R10 flag before crossing", irq_flag[0], 0);
        measure(0, c);
        check(t0_count == 8'hFF, "R4 wrap to FF", t0_count, 255);
        check(irq_flag[0] == 1'b1, "R10 flag set A", irq_flag[0], 1);
        repeat (10) @(negedge clk);
        check(irq_flag[0] == 1'b1, "R10 flag sticky A", irq_flag[0], 1);
        clr_flag(0);
        check(irq_flag[0] == 1'b0, "R11 clear A", irq_flag[0], 0);

        // R3 slow tap period
        wr_preset(0, 8'h03);
        wr_ctl(4'b0011);
        measure(0, c);
        measure(0, c);
        check(c == 1024, "R3 slow period A", c, 1024);
        wr_ctl(4'b0000);
        c = t0_count;
        repeat (40) @(negedge clk);
        check(t0_count == c, "R9 stop holds A", t0_count, c);

        // R6 internal tick for B, R5 reload
        wr_preset(1, 8'h03);
        wr_ctl(4'b0100);
        measure(1, c);
        measure(1, c);
        check(c == 4, "R6 fast period B", c, 4);
        wait_value(1, 0);
        measure(1, c);
        check(t1_count == 3, "R5 reload B", t1_count, 3);
        check(irq_flag[1] == 1'b1, "R10 flag set B", irq_flag[1], 1);

        // R8 load wins while running
        wr_preset(1, 8'h40);
        check(t1_count == 8'h40, "R8 load while running B", t1_count, 64);

        // R7 event mode: internal tick ignored
        wr_ctl(4'b1100);
        wr_preset(1, 8'h09);
        repeat (50) @(negedge clk);
        check(t1_count == 9, "R7 no internal tick in event mode", t1_count, 9);

        // R9 stopped in event mode ignores edges
        wr_ctl(4'b1000);
        pulse();
        pulse();
        check(t1_count == 9, "R9 stopped ignores edges", t1_count, 9);

        // R7/R5/R10 sweep over small presets
        wr_ctl(4'b1100);
        for (int p = 1; p <= 6; p++) begin
            clr_flag(1);
            wr_preset(1, 8'(p));
            for (int k = 1; k <= p; k++) begin
                pulse();
                check(t1_count == p - k, "R7 event decrement", t1_count, p - k);
            end
            check(irq_flag[1] == 1'b0, "R10 no flag before crossing", irq_flag[1], 0);
            pulse();
            check(t1_count == p, "R5 event reload", t1_count, p);
            check(irq_flag[1] == 1'b1, "R10 event flag", irq_flag[1], 1);
        end

        // R7 exact latency: change after third rising edge
        wr_preset(1, 8'h04);
        @(negedge clk); evt_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(t1_count == 4, "R7 no change after two edges", t1_count, 4);
        @(negedge clk);
        check(t1_count == 3, "R7 change after third edge", t1_count, 3);
        @(negedge clk); evt_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R11 clear beats simultaneous zero-crossing
        clr_flag(1);
        wr_preset(1, 8'h01);
        pulse();
        check(t1_count == 0, "R11 setup at zero", t1_count, 0);
        @(negedge clk); evt_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); flag_clr[1] = 1'b1;
        @(negedge clk); flag_clr[1] = 1'b0;
        check(t1_count == 1, "R11 reload happened", t1_count, 1);
        check(irq_flag[1] == 1'b0, "R11 clear wins", irq_flag[1], 0);
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
        check(irq_flag[1] == 1'b0, "R11 flag stays clear", irq_flag[1], 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule